// File: doc/BRIEF.md
# Opcode-Driven Register Access Port

This block sits behind a byte-level serial slave interface and turns the byte stream into accesses on a local byte-wide register array. The physical layer reports start, repeated start and stop as single-cycle pulses. It also reports each byte written by the master with a valid pulse, and each byte the master wants to read with a request pulse. Every write transaction begins with a command byte, followed by a register address byte. The command selects one of five accesses: plain write, OR-in of bits, clearing of bits, auto-incrementing multi-byte write, or auto-incrementing multi-byte read.

A multi-byte read has two phases. A write phase carries the read command and the start address. A repeated start then begins the read phase, and each read request returns the register at the pointer, after which the pointer advances. Each register modification raises a one-cycle strobe carrying the address and the value now stored, so side-effect logic elsewhere can react to it. The full register image is also exported as a flat vector. Multi-byte quantities sit least significant byte first at the lower address, which follows from the ascending pointer.

Top module: `opcode_reg_port`

## Requirements
- R1: After reset, register `a` holds the bitwise inverse of its address (`~a`), and `wr_stb` and `rd_valid` are low.
- R2: Command byte 0x08 followed by an address and one data byte stores that data byte in the addressed register.
- R3: Command byte 0x18 ORs its data byte into the addressed register. Bits that are 0 in the data byte keep their value.
- R4: Command byte 0x20 clears each bit of the addressed register that is 1 in its data byte. All other bits keep their value.
- R5: Command byte 0x28 stores every data byte that follows the address at consecutive addresses, starting at the given one. The pointer wraps from 0xFF to 0x00.
- R6: After command byte 0x30, an address and a repeated start, each read request returns on `rd_byte` the register at the pointer, with `rd_valid` high in the cycle after the request. The pointer then advances by one and wraps from 0xFF to 0x00.
- R7: An unrecognised command byte changes no register and raises no strobe. Any read request that is not inside the read phase of a 0x30 command returns 0x00.
- R8: A stop that arrives before the data byte of a 0x08, 0x18 or 0x20 command leaves every register unchanged and raises no strobe.
- R9: Each register modification raises `wr_stb` for exactly one cycle. In that cycle `wr_addr` and `wr_data` carry the target address and the value now stored, and `reg_image` already shows that value.
- R10: Bytes after the single data byte of a 0x08, 0x18 or 0x20 command are ignored until the next start or repeated start.
- R11: A repeated start followed by a written byte (rather than a read request) treats that byte as a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start condition pulse |
| bus_rstart | input | 1 | Repeated start condition pulse |
| bus_stop | input | 1 | Stop condition pulse |
| rx_valid | input | 1 | Byte written by the master is present on rx_byte |
| rx_byte | input | 8 | Written byte |
| rd_req | input | 1 | Master requests one read byte |
| rd_valid | output | 1 | Read byte present on rd_byte |
| rd_byte | output | 8 | Read data |
| wr_stb | output | 1 | One-cycle register modification strobe |
| wr_addr | output | ADDR_W | Address of the modified register |
| wr_data | output | 8 | Value now stored at wr_addr |
| reg_image | output | 8*2**ADDR_W | All registers, register a at bits [8a+7:8a] |

## Verification
The hardest situation to reach is the case where the pointer wraps inside a multi-byte burst, in both directions, while the data beyond the wrap stays distinguishable. The stimulus starts a block write at 0xFE with four distinct bytes, so two land at the top of the array and two at the bottom. A block read from 0xFE then has to return them in the same order. A second difficult case is a repeated start that is not followed by a read. Here a read command is armed and then abandoned, and the next written byte must be taken as a fresh command.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] OPC_PUT  = 8'h08;
  localparam logic [7:0] OPC_SET  = 8'h18;
  localparam logic [7:0] OPC_CLR  = 8'h20;
  localparam logic [7:0] OPC_BWR  = 8'h28;
  localparam logic [7:0] OPC_BRD  = 8'h30;

  typedef enum logic [1:0] {
    WK_PUT  = 2'd0,
    WK_OR   = 2'd1,
    WK_ANDN = 2'd2
  } wkind_e;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_OPC  = 4'd1,
    S_ADR  = 4'd2,
    S_ONE  = 4'd3,
    S_BLKW = 4'd4,
    S_SKIP = 4'd5,
    S_ARMD = 4'd6,
    S_RSEL = 4'd7,
    S_RD   = 4'd8
  } cmd_st_e;

  // Power-up contents of the test register map: inverse of the address.
  function automatic logic [BYTE_W-1:0] reg_default(input logic [BYTE_W-1:0] a);
    return ~a;
  endfunction

endpackage

// File: rtl/regacc_cmd_fsm.sv
module regacc_cmd_fsm
  import regacc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_start,
  input  logic                  bus_rstart,
  input  logic                  bus_stop,
  input  logic                  rx_valid,
  input  logic [BYTE_W-1:0]     rx_byte,
  input  logic                  rd_req,
  output logic                  do_wr,
  output wkind_e                wr_kind,
  output logic [ADDR_W-1:0]     ptr,
  output logic                  rd_hit
);

  cmd_st_e     st;
  logic [7:0]  op;
  logic        arm;
  logic        ctl;
  logic        byte_ev;
  logic        rd_ev;

  assign ctl     = bus_stop | bus_start | bus_rstart;
  assign byte_ev = rx_valid & ~ctl;
  assign rd_ev   = rd_req & ~ctl & ~rx_valid;
  assign do_wr   = byte_ev & ((st == S_ONE) | (st == S_BLKW));
  assign rd_hit  = rd_ev & arm & ((st == S_RSEL) | (st == S_RD));

  always_comb begin
    case (op)
      OPC_SET: wr_kind = WK_OR;
      OPC_CLR: wr_kind = WK_ANDN;
      default: wr_kind = WK_PUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      op  <= '0;
      ptr <= '0;
      arm <= 1'b0;
    end else if (bus_stop) begin
      st  <= S_IDLE;
      arm <= 1'b0;
    end else if (bus_start) begin
      st  <= S_OPC;
      arm <= 1'b0;
    end else if (bus_rstart) begin
      arm <= arm & ((st == S_ARMD) | (st == S_RSEL) | (st == S_RD));
      st  <= S_RSEL;
    end else if (byte_ev) begin
      case (st)
        S_OPC: begin
          op <= rx_byte;
          st <= S_ADR;
        end
        S_RSEL: begin
          op  <= rx_byte;
          st  <= S_ADR;
          arm <= 1'b0;
        end
        S_ADR: begin
          ptr <= rx_byte[ADDR_W-1:0];
          case (op)
            OPC_PUT, OPC_SET, OPC_CLR: st <= S_ONE;
            OPC_BWR:                   st <= S_BLKW;
            OPC_BRD: begin
              st  <= S_ARMD;
              arm <= 1'b1;
            end
            default:                   st <= S_SKIP;
          endcase
        end
        S_ONE:   st  <= S_SKIP;
        S_BLKW:  ptr <= ptr + 1'b1;
        default: ;
      endcase
    end else if (rd_ev) begin
      if (rd_hit) ptr <= ptr + 1'b1;
      if (st == S_RSEL) st <= S_RD;
    end
  end

  AST_PTR_STEP_BLKW: assert property (@(posedge clk) disable iff (rst)
    (do_wr && st == S_BLKW) |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R5

  AST_PTR_STEP_READ: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> ptr == ADDR_W'($past(ptr) + 1'b1)); // R6

  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st == S_SKIP && !ctl) |=> (st == S_SKIP && !do_wr)); // R10

endmodule

// File: rtl/regacc_store.sv
module regacc_store
  import regacc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        do_wr,
  input  wkind_e                      wr_kind,
  input  logic [ADDR_W-1:0]           ptr,
  input  logic [BYTE_W-1:0]           wr_byte,
  input  logic                        rd_req,
  input  logic                        rd_hit,
  output logic                        rd_valid,
  output logic [BYTE_W-1:0]           rd_byte,
  output logic                        wr_stb,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [BYTE_W-1:0]           wr_data,
  output logic [BYTE_W*(2**ADDR_W)-1:0] reg_image
);

  localparam int NREGS = 2 ** ADDR_W;

  logic [BYTE_W-1:0] mem [NREGS];
  logic [BYTE_W-1:0] cur;
  logic [BYTE_W-1:0] nxt;

  assign cur = mem[ptr];

  always_comb begin
    case (wr_kind)
      WK_OR:   nxt = cur | wr_byte;
      WK_ANDN: nxt = cur & ~wr_byte;
      default: nxt = wr_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= reg_default(BYTE_W'(i));
    end else if (do_wr) begin
      mem[ptr] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_valid <= 1'b0;
      rd_byte  <= '0;
    end else begin
      wr_stb   <= do_wr;
      if (do_wr) begin
        wr_addr <= ptr;
        wr_data <= nxt;
      end
      rd_valid <= rd_req;
      rd_byte  <= rd_hit ? cur : '0;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_image
    assign reg_image[g*BYTE_W +: BYTE_W] = mem[g];
  end

  AST_STB_MATCHES_REG: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> mem[wr_addr] == wr_data); // R9

  AST_QUIET_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |-> $stable(reg_image)); // R7

endmodule

// File: rtl/opcode_reg_port.sv
module opcode_reg_port
  import regacc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_start,
  input  logic                          bus_rstart,
  input  logic                          bus_stop,
  input  logic                          rx_valid,
  input  logic [7:0]                    rx_byte,
  input  logic                          rd_req,
  output logic                          rd_valid,
  output logic [7:0]                    rd_byte,
  output logic                          wr_stb,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [7:0]                    wr_data,
  output logic [8*(2**ADDR_W)-1:0]      reg_image
);

  logic              do_wr;
  wkind_e            wr_kind;
  logic [ADDR_W-1:0] ptr;
  logic              rd_hit;

  regacc_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .bus_start  (bus_start),
    .bus_rstart (bus_rstart),
    .bus_stop   (bus_stop),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rd_req     (rd_req),
    .do_wr      (do_wr),
    .wr_kind    (wr_kind),
    .ptr        (ptr),
    .rd_hit     (rd_hit)
  );

  regacc_store #(.ADDR_W(ADDR_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .do_wr     (do_wr),
    .wr_kind   (wr_kind),
    .ptr       (ptr),
    .wr_byte   (rx_byte),
    .rd_req    (rd_req),
    .rd_hit    (rd_hit),
    .rd_valid  (rd_valid),
    .rd_byte   (rd_byte),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .reg_image (reg_image)
  );

  AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_req)); // R6

  AST_STB_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(rx_valid)); // R9

endmodule

// File: tb/sim_opcode_reg_port.sv
module sim_opcode_reg_port;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 0, bus_rstart = 0, bus_stop = 0, rx_valid = 0, rd_req = 0;
  logic [7:0] rx_byte = '0;
  logic rd_valid, wr_stb;
  logic [7:0] rd_byte, wr_addr, wr_data;
  logic [2047:0] reg_image;

  opcode_reg_port #(.ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_rstart(bus_rstart),
    .bus_stop(bus_stop), .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .reg_image(reg_image)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [7:0] model [256];
  int    q_wa[$];
  int    q_wd[$];
  string q_wt[$];
  int    q_rd[$];
  string q_rt[$];

  task automatic report(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_stb) begin
        if (q_wa.size() == 0) begin
          report("R9", "unexpected strobe addr", int'(wr_addr), -1);
        end else begin
          automatic int    ea = q_wa.pop_front();
          automatic int    ed = q_wd.pop_front();
          automatic string et = q_wt.pop_front();
          report(et, "strobe addr", int'(wr_addr), ea);
          report(et, "strobe data", int'(wr_data), ed);
          report("R9", "image at strobe", int'(reg_image[ea*8 +: 8]), ed);
        end
      end
      if (rd_valid) begin
        if (q_rd.size() == 0) begin
          report("R6", "unexpected read", int'(rd_byte), -1);
        end else begin
          automatic int    er = q_rd.pop_front();
          automatic string rt = q_rt.pop_front();
          report(rt, "read data", int'(rd_byte), er);
        end
      end
    end
  end

  task automatic cyc(bit s, bit rs, bit sp, bit v, logic [7:0] b, bit r);
    @(negedge clk);
    bus_start = s; bus_rstart = rs; bus_stop = sp; rx_valid = v; rx_byte = b; rd_req = r;
    @(negedge clk);
    bus_start = 0; bus_rstart = 0; bus_stop = 0; rx_valid = 0; rx_byte = '0; rd_req = 0;
  endtask

  task automatic b_start();  cyc(1, 0, 0, 0, 8'h00, 0); endtask
  task automatic b_rstart(); cyc(0, 1, 0, 0, 8'h00, 0); endtask
  task automatic b_stop();   cyc(0, 0, 1, 0, 8'h00, 0); endtask
  task automatic b_byte(logic [7:0] b); cyc(0, 0, 0, 1, b, 0); endtask

  task automatic exp_wr(string tag, int a, int d);
    q_wa.push_back(a); q_wd.push_back(d); q_wt.push_back(tag);
    model[a] = 8'(d);
  endtask

  task automatic b_read(string tag, int exp);
    q_rd.push_back(exp); q_rt.push_back(tag);
    cyc(0, 0, 0, 0, 8'h00, 1);
  endtask

  task automatic check_regs(string tag);
    automatic int bad = -1;
    for (int a = 0; a < 256; a++)
      if (reg_image[a*8 +: 8] !== model[a] && bad < 0) bad = a;
    if (bad >= 0) report(tag, "register image", int'(reg_image[bad*8 +: 8]), int'(model[bad]));
    else report(tag, "register image", 0, 0);
    report(tag, "pending strobes", q_wa.size(), 0);
    report(tag, "pending reads", q_rd.size(), 0);
  endtask

  task automatic txn_one(string tag, logic [7:0] op, logic [7:0] a, logic [7:0] d);
    automatic logic [7:0] nv = (op == 8'h18) ? (model[a] | d) :
                               (op == 8'h20) ? (model[a] & ~d) : d;
    b_start(); b_byte(op); b_byte(a);
    exp_wr(tag, a, nv);
    b_byte(d); b_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) model[a] = ~8'(a);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset contents and idle outputs
    report("R1", "wr_stb after reset", int'(wr_stb), 0);
    report("R1", "rd_valid after reset", int'(rd_valid), 0);
    check_regs("R1");

    // R2 plain write, R3 OR-in, R4 clear
    txn_one("R2", 8'h08, 8'h10, 8'h3C); check_regs("R2");
    txn_one("R3", 8'h18, 8'h10, 8'h81); check_regs("R3");
    report("R3", "reg 0x10", int'(reg_image[8'h10*8 +: 8]), 8'hBD);
    txn_one("R4", 8'h20, 8'h10, 8'h0C); check_regs("R4");
    report("R4", "reg 0x10", int'(reg_image[8'h10*8 +: 8]), 8'hB1);

    // R10: extra bytes after the single data byte are ignored
    b_start(); b_byte(8'h08); b_byte(8'h20);
    exp_wr("R10", 8'h20, 8'h11);
    b_byte(8'h11); b_byte(8'h22); b_byte(8'h33); b_stop();
    check_regs("R10");

    // R5: block write across the wrap at 0xFF
    b_start(); b_byte(8'h28); b_byte(8'hFE);
    exp_wr("R5", 8'hFE, 8'h01); b_byte(8'h01);
    exp_wr("R5", 8'hFF, 8'h02); b_byte(8'h02);
    exp_wr("R5", 8'h00, 8'h03); b_byte(8'h03);
    exp_wr("R5", 8'h01, 8'h04); b_byte(8'h04);
    b_stop();
    check_regs("R5");

    // R6: block read across the wrap, then from 0x10
    b_start(); b_byte(8'h30); b_byte(8'hFE); b_rstart();
    b_read("R6", 8'h01); b_read("R6", 8'h02); b_read("R6", 8'h03); b_read("R6", 8'h04);
    b_stop();
    b_start(); b_byte(8'h30); b_byte(8'h10); b_rstart();
    b_read("R6", 8'hB1); b_read("R6", 8'hEE);
    b_stop();
    check_regs("R6");

    // R7: unknown command changes nothing; reads return zero
    b_start(); b_byte(8'h55); b_byte(8'h40); b_byte(8'hAA); b_byte(8'h55); b_stop();
    check_regs("R7");
    b_start(); b_byte(8'h55); b_byte(8'h10); b_rstart();
    b_read("R7", 8'h00); b_read("R7", 8'h00);
    b_stop();
    b_start(); b_byte(8'h08); b_read("R7", 8'h00); b_stop();
    check_regs("R7");

    // R8: stop before the data byte
    b_start(); b_byte(8'h08); b_byte(8'h40); b_stop();
    b_start(); b_byte(8'h18); b_stop();
    b_start(); b_byte(8'h20); b_byte(8'h41); b_stop();
    b_byte(8'hFF);
    check_regs("R8");

    // R11: repeated start followed by a written byte is a new command
    b_start(); b_byte(8'h30); b_byte(8'h05); b_rstart();
    b_byte(8'h08); b_byte(8'h06);
    exp_wr("R11", 8'h06, 8'h77); b_byte(8'h77);
    b_stop();
    check_regs("R11");
    b_start(); b_byte(8'h30); b_byte(8'h05); b_rstart();
    b_read("R11", 8'hFA); b_read("R11", 8'h77);
    b_stop();

    // R9: strobe is single-cycle
    txn_one("R9", 8'h08, 8'h80, 8'h5A);
    report("R9", "wr_stb idle after write", int'(wr_stb), 0);
    check_regs("R9");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule